// File: doc/BRIEF.md
# Double-Buffered Cell Transmit Port

This block sends fixed-length cells out of one 4-bit output lane. The lane has its own clock, `out_clk`, which is not related to the system clock. A controller in the `sys_clk` domain writes the bytes of a cell into a free buffer, one byte per cycle at an address it picks. It then pulses `commit` to hand that buffer to the transmitter. There are two buffers. While one is on the wire, the other can be filled. If the second buffer was handed over in time, the next cell follows the current one with no gap.

On the lane side, every cell starts with a one-cycle framing strobe. The strobe is high in the same cycle as the first nibble. When nothing is waiting at the end of a cell, the lane goes quiet: the data lines are zero and there is no strobe. The controller polls `buf_empty` to learn when it may load the next cell. The cell length comes from a small length select, is shared by every cell, and is set apart from any receive-side length.

Ownership of each buffer moves between the domains as toggle flags. Each flag passes through a multi-stage synchronizer. A write or a commit aimed at a buffer the transmitter still owns is dropped.

Top module: `cellport_out`

## Requirements
- R1: A cell is sent as its bytes in address order 0, 1, …, N-1. Within each byte, bits 7:4 go first and bits 3:0 second. One nibble is sent per `out_clk` cycle.
- R2: `cell_len_sel` values 0 to 4 give cells of 52 + value bytes. Values 5 to 7 give 56 bytes. A cell takes twice its byte count in `out_clk` cycles. The select is changed only while no cell is pending or being sent.
- R3: `out_frame` is high for exactly one `out_clk` cycle per cell, in the cycle that carries the cell's first nibble, and at no other time.
- R4: After reset, and whenever a cell ends with no other cell committed, `out_data` is zero and `out_frame` is low.
- R5: If the other buffer was committed before the last nibble of the current cell, the next cell's first nibble, with its strobe, comes in the very next `out_clk` cycle.
- R6: `buf_empty` is high after reset. A commit while `buf_empty` is high hands the buffer over. `buf_empty` is low while both buffers are held: one being sent and one waiting.
- R7: While `buf_empty` is low, writes and commits are ignored. Pending cell contents do not change, and no extra cell is sent.
- R8: After the last nibble of the cell that held the controller's next buffer, `buf_empty` rises again once the synchronizer delay has passed.
- R9: Cells leave in the order in which they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Controller-side clock |
| sys_rst_n | input | 1 | Active-low async reset, controller domain |
| out_clk | input | 1 | Lane clock |
| out_rst_n | input | 1 | Active-low async reset, lane domain |
| cell_len_sel | input | SEL_W | Cell length select (R2) |
| wr_en | input | 1 | Write one byte into the buffer being filled |
| wr_addr | input | ADDR_W | Byte address within the cell |
| wr_data | input | 8 | Byte to write |
| commit | input | 1 | Hand the filled buffer to the transmitter |
| buf_empty | output | 1 | A buffer is free for loading |
| out_data | output | 4 | Lane nibble |
| out_frame | output | 1 | Start-of-cell strobe |

## Verification
The bench sweeps every length select, including the three clamped codes. It compares every nibble, and every idle cycle, against a pattern it computes itself. A port that swapped nibble order, counted the length wrong or clamped the wrong way would show nibble mismatches or a strobe in the wrong cycle. The bench also loads a second cell while the first is on the wire. Then, with both buffers held, it tries to overwrite and commit a third. A design that left a gap between cells would miss the back-to-back count. A design that accepted the overwrite would corrupt the waiting cell or send an extra one. A design that never released a buffer would leave `buf_empty` stuck low.

// File: rtl/cellport_pkg.sv
package cellport_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef logic [BYTE_W-1:0] byte_t;

  // Byte count of a cell for a length select, clamped to the largest size.
  function automatic int cell_bytes(input int sel, input int min_b, input int max_b);
    int b;
    b = min_b + sel;
    if (b > max_b) b = max_b;
    return b;
  endfunction

  // Nibble of a byte: upper half when lo is 0, lower half when lo is 1.
  function automatic logic [NIB_W-1:0] pick_nibble(input byte_t b, input logic lo);
    return lo ? b[NIB_W-1:0] : b[BYTE_W-1:NIB_W];
  endfunction

endpackage

// File: rtl/cellport_sync.sv
module cellport_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cellport_fill.sv
module cellport_fill
  import cellport_pkg::*;
#(
  parameter int DEPTH  = 56,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic              commit,
  input  logic [1:0]        done_sync,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output byte_t             rd_byte,
  output logic [1:0]        ld_tog,
  output logic              buf_empty,
  output logic              fill_sel,
  output logic              accept_evt
);

  logic [1:0] held;
  logic       target_free;
  logic       write_hit;
  byte_t      bank_q [2];

  // A buffer is held by the lane while its load toggle differs from its
  // synchronized done toggle.
  assign held        = ld_tog ^ done_sync;
  assign target_free = !held[fill_sel];
  assign write_hit   = wr_en && target_free && (int'(wr_addr) < DEPTH);
  assign accept_evt  = commit && target_free;
  assign buf_empty   = target_free;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
      if (write_hit && (fill_sel == 1'(b))) cells[wr_addr] <= wr_data;
    end

    assign bank_q[b] = (int'(rd_addr) < DEPTH) ? cells[rd_addr] : '0;
  end

  assign rd_byte = bank_q[rd_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_tog   <= '0;
      fill_sel <= 1'b0;
    end else if (accept_evt) begin
      ld_tog[fill_sel] <= ~ld_tog[fill_sel];
      fill_sel         <= ~fill_sel;
    end
  end

endmodule

// File: rtl/cellport_tx.sv
module cellport_tx
  import cellport_pkg::*;
#(
  parameter int MIN_B  = 52,
  parameter int MAX_B  = 56,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  len_sel,
  input  logic [1:0]        ld_sync,
  input  byte_t             rd_byte,
  output logic              rd_bank,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        done_tog,
  output logic [NIB_W-1:0]  out_data,
  output logic              out_frame,
  output logic              active,
  output logic              start_evt,
  output logic              swap_evt
);

  logic             tx_sel;
  logic [CNT_W-1:0] nib_cnt;
  logic [CNT_W-1:0] nib_last;
  logic [CNT_W-1:0] next_idx;
  logic [1:0]       ready;
  logic             boundary;
  logic             next_bank;

  assign nib_last  = CNT_W'(2 * cell_bytes(int'(len_sel), MIN_B, MAX_B) - 1);
  assign ready     = ld_sync ^ done_tog;
  assign swap_evt  = active && (nib_cnt == nib_last);
  assign boundary  = !active || swap_evt;
  assign next_bank = swap_evt ? ~tx_sel : tx_sel;
  assign start_evt = boundary && ready[next_bank];
  assign next_idx  = boundary ? '0 : nib_cnt + CNT_W'(1);
  assign rd_bank   = next_bank;
  assign rd_addr   = next_idx[CNT_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sel    <= 1'b0;
      done_tog  <= '0;
      nib_cnt   <= '0;
      active    <= 1'b0;
      out_data  <= '0;
      out_frame <= 1'b0;
    end else begin
      if (swap_evt) begin
        done_tog[tx_sel] <= ~done_tog[tx_sel];
        tx_sel           <= ~tx_sel;
      end
      if (boundary && !start_evt) begin
        active    <= 1'b0;
        nib_cnt   <= '0;
        out_data  <= '0;
        out_frame <= 1'b0;
      end else begin
        active    <= 1'b1;
        nib_cnt   <= next_idx;
        out_data  <= pick_nibble(rd_byte, next_idx[0]);
        out_frame <= boundary;
      end
    end
  end

endmodule

// File: rtl/cellport_out.sv
module cellport_out
  import cellport_pkg::*;
#(
  parameter int MIN_BYTES   = 52,
  parameter int MAX_BYTES   = 56,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(MAX_BYTES),
  localparam int CNT_W      = ADDR_W + 1
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              out_clk,
  input  logic              out_rst_n,
  input  logic [SEL_W-1:0]  cell_len_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              commit,
  output logic              buf_empty,
  output logic [3:0]        out_data,
  output logic              out_frame
);

  logic [1:0]        ld_tog;
  logic [1:0]        ld_sync;
  logic [1:0]        done_tog;
  logic [1:0]        done_sync;
  logic              rd_bank;
  logic [ADDR_W-1:0] rd_addr;
  byte_t             rd_byte;
  logic              fill_sel;
  logic              accept_evt;
  logic              tx_active;
  logic              start_evt;
  logic              swap_evt;

  cellport_fill #(.DEPTH(MAX_BYTES), .ADDR_W(ADDR_W)) u_fill (
    .clk        (sys_clk),
    .rst_n      (sys_rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .commit     (commit),
    .done_sync  (done_sync),
    .rd_bank    (rd_bank),
    .rd_addr    (rd_addr),
    .rd_byte    (rd_byte),
    .ld_tog     (ld_tog),
    .buf_empty  (buf_empty),
    .fill_sel   (fill_sel),
    .accept_evt (accept_evt)
  );

  cellport_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ld_sync (
    .clk (out_clk), .rst_n (out_rst_n), .d (ld_tog), .q (ld_sync)
  );

  cellport_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_done_sync (
    .clk (sys_clk), .rst_n (sys_rst_n), .d (done_tog), .q (done_sync)
  );

  cellport_tx #(
    .MIN_B (MIN_BYTES), .MAX_B (MAX_BYTES), .SEL_W (SEL_W),
    .ADDR_W(ADDR_W), .CNT_W (CNT_W)
  ) u_tx (
    .clk       (out_clk),
    .rst_n     (out_rst_n),
    .len_sel   (cell_len_sel),
    .ld_sync   (ld_sync),
    .rd_byte   (rd_byte),
    .rd_bank   (rd_bank),
    .rd_addr   (rd_addr),
    .done_tog  (done_tog),
    .out_data  (out_data),
    .out_frame (out_frame),
    .active    (tx_active),
    .start_evt (start_evt),
    .swap_evt  (swap_evt)
  );

endmodule

// File: rtl/cellport_out_chk.sv
module cellport_out_chk
  import cellport_pkg::*;
#(
  parameter int MIN_BYTES = 52,
  parameter int MAX_BYTES = 56,
  parameter int SEL_W     = 3
) (
  input logic             sys_clk,
  input logic             sys_rst_n,
  input logic             out_clk,
  input logic             out_rst_n,
  input logic [SEL_W-1:0] cell_len_sel,
  input logic             commit,
  input logic             buf_empty,
  input logic             fill_sel,
  input logic [3:0]       out_data,
  input logic             out_frame,
  input logic             tx_active,
  input logic             start_evt,
  input logic             swap_evt
);

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge out_clk or negedge out_rst_n) begin
    if (!out_rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (out_frame) begin
      gap  <= 16'd1;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  // R3
  frame_single_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    out_frame |=> !out_frame);

  // R3
  frame_after_start_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    start_evt |=> (out_frame && tx_active));

  // R4
  idle_quiet_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    !tx_active |-> (out_data == 4'h0 && !out_frame));

  // R2
  cell_spacing_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    (out_frame && seen) |-> (int'(gap) >= 2 * cell_bytes(int'(cell_len_sel), MIN_BYTES, MAX_BYTES)));

  // R5
  swap_next_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    swap_evt |=> (out_frame || !tx_active));

  // R7
  ignored_load_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (commit && !buf_empty) |=> $stable(fill_sel));

  // R6
  accept_flip_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (commit && buf_empty) |=> (fill_sel != $past(fill_sel)));

endmodule

bind cellport_out cellport_out_chk #(
  .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES), .SEL_W(SEL_W)
) u_chk (
  .sys_clk      (sys_clk),
  .sys_rst_n    (sys_rst_n),
  .out_clk      (out_clk),
  .out_rst_n    (out_rst_n),
  .cell_len_sel (cell_len_sel),
  .commit       (commit),
  .buf_empty    (buf_empty),
  .fill_sel     (fill_sel),
  .out_data     (out_data),
  .out_frame    (out_frame),
  .tx_active    (tx_active),
  .start_evt    (start_evt),
  .swap_evt     (swap_evt)
);

// File: tb/cellport_out_tb.sv
module cellport_out_tb;

  logic       sys_clk = 1'b0;
  logic       out_clk = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       out_rst_n = 1'b0;
  logic [2:0] cell_len_sel = 3'd0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       commit = 1'b0;
  logic       buf_empty;
  logic [3:0] out_data;
  logic       out_frame;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  int exp_tag [64];
  int exp_len [64];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int cells_done = 0;
  int frames = 0;
  int seamless_cnt = 0;

  always #5 sys_clk = ~sys_clk;
  always #7 out_clk = ~out_clk;

  cellport_out u_dut (
    .sys_clk (sys_clk), .sys_rst_n (sys_rst_n),
    .out_clk (out_clk), .out_rst_n (out_rst_n),
    .cell_len_sel (cell_len_sel),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .commit (commit), .buf_empty (buf_empty),
    .out_data (out_data), .out_frame (out_frame)
  );

  // Byte count per select: 52..56 for 0..4, 56 for larger codes.
  function automatic int len_of(input int sel);
    case (sel)
      0: return 52;
      1: return 53;
      2: return 54;
      3: return 55;
      default: return 56;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int tag, input int i);
    return 8'((tag * 37 + i * 11 + 5) % 256);
  endfunction

  function automatic int exp_nib(input int tag, input int n);
    logic [7:0] b;
    b = pat(tag, n / 2);
    return (n % 2 == 0) ? int'(b) / 16 : int'(b) % 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Lane monitor: every nibble and every idle cycle is compared.
  int cur = 0;
  int nib_idx = 0;
  int since = 0;
  int prev_nib = 0;
  bit in_cell = 1'b0;
  bit seen_frame = 1'b0;

  always @(negedge out_clk) begin
    if (mon_en && out_rst_n) begin
      if (out_frame) begin
        chk(!in_cell, "R3 strobe inside a cell", nib_idx, 0);
        chk(rd_ptr < wr_ptr, "R7 cell without commit", rd_ptr, wr_ptr);
        if (seen_frame && since == prev_nib) seamless_cnt++;
        cur = rd_ptr;
        rd_ptr++;
        frames++;
        nib_idx = 0;
        in_cell = 1'b1;
        since = 0;
        seen_frame = 1'b1;
      end
      if (in_cell) begin
        chk(int'(out_data) == exp_nib(exp_tag[cur], nib_idx), "R1 R9 nibble",
            int'(out_data), exp_nib(exp_tag[cur], nib_idx));
        nib_idx++;
        if (nib_idx == 2 * exp_len[cur]) begin
          in_cell = 1'b0;
          prev_nib = 2 * exp_len[cur];
          cells_done++;
        end
      end else if (!out_frame) begin
        chk(out_data == 4'h0, "R4 idle data", int'(out_data), 0);
      end
      since++;
    end
  end

  task automatic load_cell(input int tag);
    int n;
    n = len_of(int'(cell_len_sel));
    while (!buf_empty) @(negedge sys_clk);
    exp_tag[wr_ptr] = tag;
    exp_len[wr_ptr] = n;
    wr_ptr++;
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1;
      wr_addr = 6'(i);
      wr_data = pat(tag, i);
      @(negedge sys_clk);
    end
    wr_en = 1'b0;
    commit = 1'b1;
    @(negedge sys_clk);
    commit = 1'b0;
  endtask

  task automatic wait_idle();
    while (cells_done < wr_ptr) @(negedge out_clk);
    repeat (20) @(negedge out_clk);
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", cells_done, wr_ptr);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge sys_clk);
    sys_rst_n = 1'b1;
    out_rst_n = 1'b1;
    repeat (3) @(negedge out_clk);
    // R4 and R6 reset state
    chk(out_data == 4'h0, "R4 reset data", int'(out_data), 0);
    chk(!out_frame, "R4 reset strobe", int'(out_frame), 0);
    @(negedge sys_clk);
    chk(buf_empty, "R6 reset empty", int'(buf_empty), 1);
    mon_en = 1'b1;

    // Two cells back to back, then a load attempt with both buffers held.
    cell_len_sel = 3'd0;
    load_cell(1);
    chk(buf_empty, "R6 second buffer free", int'(buf_empty), 1);
    load_cell(2);
    chk(!buf_empty, "R6 both held", int'(buf_empty), 0);
    for (int i = 0; i < 8; i++) begin
      wr_en = 1'b1;
      wr_addr = 6'(i);
      wr_data = 8'hEE;
      @(negedge sys_clk);
    end
    wr_en = 1'b0;
    commit = 1'b1;
    @(negedge sys_clk);
    commit = 1'b0;
    chk(!buf_empty, "R7 load ignored", int'(buf_empty), 0);
    begin
      int waited = 0;
      while (!buf_empty && waited < 3000) begin
        @(negedge sys_clk);
        waited++;
      end
      chk(buf_empty, "R8 buffer released", int'(buf_empty), 1);
    end
    wait_idle();

    // R2 sweep of every length code, three cells each.
    for (int s = 0; s < 8; s++) begin
      cell_len_sel = 3'(s);
      repeat (4) @(negedge sys_clk);
      for (int k = 0; k < 3; k++) load_cell(10 + s * 3 + k);
      wait_idle();
    end

    repeat (300) @(negedge out_clk);
    chk(frames == wr_ptr, "R7 R9 cell count", frames, wr_ptr);
    chk(cells_done == wr_ptr, "R2 complete cells", cells_done, wr_ptr);
    chk(seamless_cnt >= 9, "R5 back-to-back cells", seamless_cnt, 9);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule